// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block turns a programmed mode word and a starting column into the stream of column addresses that one read or write burst visits, one address per clock. It sits beside a memory controller's command logic. That logic loads the mode word once and then pulses a start for every column command. It uses the per-beat column, the valid flag and the last-beat flag to address the array.

The mode word sets several things. It gives the burst length: 1, 2, 4 or 8 beats, or a whole 512-column row. It selects sequential or interleaved ordering inside the aligned block, and an option that shortens every write burst to one location. It also carries a CAS-latency field. The block only decodes that field and reports its value. A length code that is not allowed raises an error flag, and the burst then runs as a single beat. A stop input ends a running burst at any beat. A new start abandons any burst in flight.

Top module: `sdram_burst_colgen`

## Requirements
- R1: While reset is asserted and after its release, `beat_valid`, `beat_last` and `len_err` are 0, and `cas_lat` is 0.
- R2: Mode bits [2:0] select the burst length: 000 gives 1 beat, 001 gives 2, 010 gives 4 and 011 gives 8. The first beat appears in the cycle after the start edge. `beat_last` is high only on the final beat, and `beat_valid` drops in the cycle after it.
- R3: With mode bit 3 = 0 (sequential), the low log2(length) column bits count up from the start column and wrap inside the aligned block. The upper column bits hold the start value.
- R4: With mode bit 3 = 1 (interleaved), beat k carries low bits equal to (start low bits XOR k). The upper bits hold the start value.
- R5: With length code 000, the ordering bit has no effect, and only the start column is emitted.
- R6: With mode bit 9 = 1, a burst started with `start_wr` = 1 has one beat. A burst started with `start_wr` = 0 keeps the programmed length.
- R7: `cas_lat` reports mode bits [6:4]: 010 gives 2, 011 gives 3, and any other code gives 0.
- R8: Length code 111 with bit 3 = 0 is a full-page burst. The column advances by one modulo 512 on every beat, and `beat_last` never rises.
- R9: `stop` sampled high during a burst, with no start on the same edge, makes `beat_valid` low in the next cycle.
- R10: Length codes 100, 101 and 110, and code 111 with bit 3 = 1, set `len_err` = 1, and bursts then have exactly one beat.
- R11: A start during a running burst wins over the old burst and over `stop`. The next cycle shows the new start column as beat 0.
- R12: A mode load takes effect on its clock edge. A burst already running keeps the length and ordering it started with.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_load | input | 1 | Capture `mode_word` on this edge |
| mode_word | input | 12 | Mode opcode (length, ordering, latency, write-single) |
| start | input | 1 | Begin a burst at `start_col` |
| start_col | input | 9 | Starting column |
| start_wr | input | 1 | 1 = write burst, 0 = read burst |
| stop | input | 1 | Terminate the running burst |
| col_out | output | 9 | Column for the current beat |
| beat_valid | output | 1 | A beat is being issued this cycle |
| beat_last | output | 1 | Current beat is the final one of a bounded burst |
| len_err | output | 1 | Programmed length code is reserved |
| cas_lat | output | 3 | Decoded CAS latency (2, 3, or 0 when reserved) |

## Verification
The hardest cases to reach are the wrap of a full-page burst across column 511 and the clean ending of that endless burst. The stimulus starts a page burst two columns below the row end, follows it for more than a full row, and then ends it with `stop`. It is also hard to show that a burst in flight holds its length while the mode word changes under it. The stimulus reloads the mode word in the middle of a four-beat burst, then starts a new burst to show the new length.

// File: rtl/colgen_pkg.sv
package colgen_pkg;
  localparam int OP_W    = 12;
  localparam int BLK_W   = 3;   // widest bounded block is 8 beats
  localparam int ORD_BIT = 3;
  localparam int WSG_BIT = 9;

  typedef enum logic [2:0] {
    LEN_1    = 3'b000,
    LEN_2    = 3'b001,
    LEN_4    = 3'b010,
    LEN_8    = 3'b011,
    LEN_PAGE = 3'b111
  } len_code_e;

  typedef struct packed {
    logic       ilv;      // interleaved ordering
    logic       wsingle;  // writes collapse to one beat
    logic       full;     // full-page burst
    logic       err;      // reserved length code
    logic [2:0] cas;      // decoded latency, 0 if reserved
  } mode_fields_t;
endpackage

// File: rtl/colgen_mode.sv
module colgen_mode
  import colgen_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [OP_W-1:0]     op,
  output mode_fields_t        fld,
  output logic [COL_W-1:0]    mask
);
  logic [OP_W-1:0] op_q, op_d;

  always_comb begin
    op_d = op_q;
    if (load) op_d = op;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) op_q <= '0;
    else        op_q <= op_d;
  end

  always_comb begin
    fld         = '0;
    mask        = '0;
    fld.ilv     = op_q[ORD_BIT];
    fld.wsingle = op_q[WSG_BIT];
    case (op_q[2:0])
      LEN_1, LEN_2, LEN_4, LEN_8:
        mask[BLK_W-1:0] = BLK_W'((4'd1 << op_q[1:0]) - 4'd1);
      LEN_PAGE: begin
        if (!op_q[ORD_BIT]) begin
          mask     = '1;
          fld.full = 1'b1;
        end else begin
          fld.err  = 1'b1;
        end
      end
      default: fld.err = 1'b1;
    endcase
    case (op_q[6:4])
      3'b010:  fld.cas = 3'd2;
      3'b011:  fld.cas = 3'd3;
      default: fld.cas = 3'd0;
    endcase
  end

  // R10: an error code always leaves a single-beat block
  a_r10_err_single: assert property (@(posedge clk) disable iff (!rst_n)
    fld.err |-> (mask == '0));
  // R8: a page burst spans the whole row
  a_r8_page_mask: assert property (@(posedge clk) disable iff (!rst_n)
    fld.full |-> (&mask));
  // R7: only legal latencies are reported
  always_comb if (rst_n) a_r7_cas_legal: assert (fld.cas == 3'd0 || fld.cas == 3'd2 || fld.cas == 3'd3);
endmodule

// File: rtl/colgen_seq.sv
module colgen_seq
  import colgen_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [COL_W-1:0]   start_col,
  input  logic               start_wr,
  input  logic               stop,
  input  mode_fields_t       fld,
  input  logic [COL_W-1:0]   mask,
  output logic               active,
  output logic [COL_W-1:0]   base,
  output logic [COL_W-1:0]   cnt,
  output logic [COL_W-1:0]   mask_q,
  output logic               ilv_q,
  output logic               last
);
  logic               act_d, ilv_d, full_q, full_d;
  logic [COL_W-1:0]   base_d, cnt_d, mask_d;
  logic               one_wr;

  assign one_wr = fld.wsingle && start_wr;
  assign last   = active && !full_q && (cnt == mask_q);

  always_comb begin
    act_d  = active;
    base_d = base;
    cnt_d  = cnt;
    mask_d = mask_q;
    ilv_d  = ilv_q;
    full_d = full_q;
    if (start) begin
      act_d  = 1'b1;
      base_d = start_col;
      cnt_d  = '0;
      mask_d = one_wr ? '0 : mask;
      ilv_d  = fld.ilv;
      full_d = fld.full && !one_wr;
    end else if (active && stop) begin
      act_d  = 1'b0;
    end else if (active) begin
      if (last) act_d = 1'b0;
      else      cnt_d = cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      base   <= '0;
      cnt    <= '0;
      mask_q <= '0;
      ilv_q  <= 1'b0;
      full_q <= 1'b0;
    end else begin
      active <= act_d;
      base   <= base_d;
      cnt    <= cnt_d;
      mask_q <= mask_d;
      ilv_q  <= ilv_d;
      full_q <= full_d;
    end
  end

  // R9: stop ends the burst on the next cycle
  a_r9_stop_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (active && stop && !start) |=> !active);
  // R11: a start always opens a fresh burst at its column
  a_r11_restart: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (active && cnt == '0 && base == $past(start_col)));
  // R2: the beat counter never passes the block size
  a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (cnt <= mask_q));
  // R8: a page burst is never marked last
  a_r8_page_open: assert property (@(posedge clk) disable iff (!rst_n)
    (active && full_q && !start && !stop) |=> active);
endmodule

// File: rtl/colgen_addr.sv
module colgen_addr #(
  parameter int COL_W = 9
) (
  input  logic [COL_W-1:0] base,
  input  logic [COL_W-1:0] cnt,
  input  logic [COL_W-1:0] mask,
  input  logic             ilv,
  output logic [COL_W-1:0] col
);
  logic [COL_W-1:0] seq_v, xor_v, ord_v;

  assign seq_v = base + cnt;
  assign xor_v = base ^ cnt;
  assign ord_v = ilv ? xor_v : seq_v;

  for (genvar i = 0; i < COL_W; i++) begin : g_bit
    // masked bits follow the burst order, the rest hold the start column
    assign col[i] = mask[i] ? ord_v[i] : base[i];
  end
endmodule

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen
  import colgen_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_load,
  input  logic [11:0]      mode_word,
  input  logic             start,
  input  logic [COL_W-1:0] start_col,
  input  logic             start_wr,
  input  logic             stop,
  output logic [COL_W-1:0] col_out,
  output logic             beat_valid,
  output logic             beat_last,
  output logic             len_err,
  output logic [2:0]       cas_lat
);
  mode_fields_t     fld;
  logic [COL_W-1:0] mask, base, cnt, mask_q;
  logic             active, ilv_q, last;

  colgen_mode #(.COL_W(COL_W)) u_mode (
    .clk(clk), .rst_n(rst_n), .load(mode_load), .op(mode_word),
    .fld(fld), .mask(mask)
  );

  colgen_seq #(.COL_W(COL_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .start_col(start_col),
    .start_wr(start_wr), .stop(stop), .fld(fld), .mask(mask),
    .active(active), .base(base), .cnt(cnt), .mask_q(mask_q),
    .ilv_q(ilv_q), .last(last)
  );

  colgen_addr #(.COL_W(COL_W)) u_addr (
    .base(base), .cnt(cnt), .mask(mask_q), .ilv(ilv_q), .col(col_out)
  );

  assign beat_valid = active;
  assign beat_last  = last;
  assign len_err    = fld.err;
  assign cas_lat    = fld.cas;

  // R2: last only appears on a valid beat
  a_r2_last_valid: assert property (@(posedge clk) disable iff (!rst_n)
    beat_last |-> beat_valid);
  // R3 and R4: bits outside the block hold across beats
  a_r3_upper_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && !beat_last && !start && !stop)
      |=> ((col_out & ~mask_q) == ($past(col_out) & ~$past(mask_q))));
  // R11: the first beat of a new burst is its start column
  a_r11_first_col: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (beat_valid && col_out == $past(start_col)));
endmodule

// File: tb/tb_sdram_burst_colgen.sv
module tb_sdram_burst_colgen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_load = 1'b0;
  logic [11:0] mode_word = '0;
  logic       start = 1'b0;
  logic [8:0] start_col = '0;
  logic       start_wr = 1'b0;
  logic       stop = 1'b0;
  logic [8:0] col_out;
  logic       beat_valid, beat_last, len_err;
  logic [2:0] cas_lat;
  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  sdram_burst_colgen dut (
    .clk(clk), .rst_n(rst_n), .mode_load(mode_load), .mode_word(mode_word),
    .start(start), .start_col(start_col), .start_wr(start_wr), .stop(stop),
    .col_out(col_out), .beat_valid(beat_valid), .beat_last(beat_last),
    .len_err(len_err), .cas_lat(cas_lat)
  );

  // {op12, col9, wr1, beats4, err1, cas3, eight expected columns of 9}
  localparam int VW = 102;
  localparam int NV = 13;
  localparam logic [VW-1:0] VEC [NV] = '{
    {12'h000, 9'h05A, 1'b0, 4'd1, 1'b0, 3'd0, 9'h05A, 9'h0, 9'h0, 9'h0, 9'h0, 9'h0, 9'h0, 9'h0},
    {12'h008, 9'h123, 1'b0, 4'd1, 1'b0, 3'd0, 9'h123, 9'h0, 9'h0, 9'h0, 9'h0, 9'h0, 9'h0, 9'h0},
    {12'h021, 9'h0FF, 1'b0, 4'd2, 1'b0, 3'd2, 9'h0FF, 9'h0FE, 9'h0, 9'h0, 9'h0, 9'h0, 9'h0, 9'h0},
    {12'h002, 9'h106, 1'b0, 4'd4, 1'b0, 3'd0, 9'h106, 9'h107, 9'h104, 9'h105, 9'h0, 9'h0, 9'h0, 9'h0},
    {12'h00A, 9'h0A1, 1'b0, 4'd4, 1'b0, 3'd0, 9'h0A1, 9'h0A0, 9'h0A3, 9'h0A2, 9'h0, 9'h0, 9'h0, 9'h0},
    {12'h003, 9'h1FD, 1'b0, 4'd8, 1'b0, 3'd0, 9'h1FD, 9'h1FE, 9'h1FF, 9'h1F8, 9'h1F9, 9'h1FA, 9'h1FB, 9'h1FC},
    {12'h00B, 9'h016, 1'b0, 4'd8, 1'b0, 3'd0, 9'h016, 9'h017, 9'h014, 9'h015, 9'h012, 9'h013, 9'h010, 9'h011},
    {12'h203, 9'h0C3, 1'b1, 4'd1, 1'b0, 3'd0, 9'h0C3, 9'h0, 9'h0, 9'h0, 9'h0, 9'h0, 9'h0, 9'h0},
    {12'h203, 9'h0C3, 1'b0, 4'd8, 1'b0, 3'd0, 9'h0C3, 9'h0C4, 9'h0C5, 9'h0C6, 9'h0C7, 9'h0C0, 9'h0C1, 9'h0C2},
    {12'h004, 9'h077, 1'b0, 4'd1, 1'b1, 3'd0, 9'h077, 9'h0, 9'h0, 9'h0, 9'h0, 9'h0, 9'h0, 9'h0},
    {12'h00F, 9'h055, 1'b0, 4'd1, 1'b1, 3'd0, 9'h055, 9'h0, 9'h0, 9'h0, 9'h0, 9'h0, 9'h0, 9'h0},
    {12'h032, 9'h009, 1'b0, 4'd4, 1'b0, 3'd3, 9'h009, 9'h00A, 9'h00B, 9'h008, 9'h0, 9'h0, 9'h0, 9'h0},
    {12'h073, 9'h1AA, 1'b1, 4'd8, 1'b0, 3'd0, 9'h1AA, 9'h1AB, 9'h1AC, 9'h1AD, 9'h1AE, 9'h1AF, 9'h1A8, 9'h1A9}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic load_mode(input logic [11:0] op);
    mode_load = 1'b1;
    mode_word = op;
    step();
    mode_load = 1'b0;
  endtask

  task automatic start_burst(input logic [8:0] c, input logic wr);
    start = 1'b1;
    start_col = c;
    start_wr = wr;
    step();
    start = 1'b0;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!beat_valid && !beat_last, "R1 outputs idle in reset", {beat_valid, beat_last}, 0);
    chk(!len_err && cas_lat == 3'd0, "R1 mode flags in reset", {len_err, cas_lat}, 0);
    rst_n = 1'b1;
    step();
    chk(!beat_valid, "R1 idle after release", beat_valid, 0);

    // R2 R3 R4 R5 R6 R7 R10: table walk
    for (int v = 0; v < NV; v++) begin
      logic [VW-1:0] e;
      int n;
      e = VEC[v];
      n = int'(e[79:76]);
      load_mode(e[101:90]);
      chk(len_err == e[75], "R10 len_err", len_err, e[75]);
      chk(cas_lat == e[74:72], "R7 cas_lat", cas_lat, e[74:72]);
      start_burst(e[89:81], e[80]);
      for (int i = 0; i < n; i++) begin
        logic [8:0] ec;
        ec = e[71-9*i -: 9];
        chk(beat_valid && col_out == ec, "R2 R3 R4 R5 R6 beat column", col_out, ec);
        chk(beat_last == (i == n - 1), "R2 last flag", beat_last, (i == n - 1));
        step();
      end
      chk(!beat_valid, "R2 R6 R10 burst over", beat_valid, 0);
    end

    // R8: full page wraps across 511 and never ends on its own
    begin
      int bad;
      bad = 0;
      load_mode(12'h007);
      start_burst(9'h1FE, 1'b0);
      for (int i = 0; i < 600; i++) begin
        if (!beat_valid || beat_last || col_out != 9'((9'h1FE + i) % 512)) bad++;
        step();
      end
      chk(bad == 0, "R8 page beats wrong", bad, 0);
      chk(beat_valid && col_out == 9'((9'h1FE + 600) % 512), "R8 page still running", col_out, (9'h1FE + 600) % 512);
      // R9: stop the page burst
      stop = 1'b1;
      step();
      stop = 1'b0;
      chk(!beat_valid, "R9 stop ends page burst", beat_valid, 0);
    end

    // R9: stop a bounded burst on its second beat
    load_mode(12'h003);
    start_burst(9'h040, 1'b0);
    step();
    chk(beat_valid && col_out == 9'h041, "R9 beat before stop", col_out, 9'h041);
    stop = 1'b1;
    step();
    stop = 1'b0;
    chk(!beat_valid, "R9 stop mid burst", beat_valid, 0);

    // R11: restart during a burst, with stop raised on the same edge
    start_burst(9'h100, 1'b0);
    step();
    stop = 1'b1;
    start_burst(9'h055, 1'b0);
    stop = 1'b0;
    chk(beat_valid && col_out == 9'h055, "R11 new burst first beat", col_out, 9'h055);
    step();
    chk(beat_valid && col_out == 9'h056, "R11 new burst second beat", col_out, 9'h056);
    stop = 1'b1;
    step();
    stop = 1'b0;

    // R12: mode change mid burst leaves the running burst alone
    load_mode(12'h002);
    start_burst(9'h010, 1'b0);
    load_mode(12'h000);
    chk(beat_valid && col_out == 9'h011 && !beat_last, "R12 beat 1 kept", col_out, 9'h011);
    step();
    chk(beat_valid && col_out == 9'h012, "R12 beat 2 kept", col_out, 9'h012);
    step();
    chk(beat_valid && col_out == 9'h013 && beat_last, "R12 beat 3 last", col_out, 9'h013);
    step();
    chk(!beat_valid, "R12 old burst done", beat_valid, 0);
    start_burst(9'h010, 1'b0);
    chk(beat_valid && beat_last && col_out == 9'h010, "R12 new length used", {beat_last, col_out}, {1'b1, 9'h010});
    step();
    chk(!beat_valid, "R12 single beat over", beat_valid, 0);

    finish_run();
  end
endmodule